// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. It keeps four 16-bit segment registers (code, data, stack and extra). It selects one of them from the kind of access being made, multiplies it by 16 and adds the offset. Any carry past the top address bit is dropped, so the address space wraps at 1 MB.

A caller presents an access-kind code, an offset and, when needed, a segment override. The address is formed combinationally from the registered segment values. Segment registers are loaded through one write port and the new value takes effect at the next clock edge. Instruction fetches and string destinations keep their fixed segment even when an override is given. Every other access kind accepts the override.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals the selected segment value times 16 plus `offset`. For example, segment 2050h with offset 0004h gives 20504h.
- R2: A sum above FFFFFh wraps modulo 2^20. FFFFh:0010h gives 00000h and FFFFh:FFFFh gives 0FFEFh.
- R3: Access kind 0 (instruction fetch) always uses the code segment, whatever the override inputs are.
- R4: Access kind 1 (stack push/pop) and access kind 2 (base-pointer relative) use the stack segment when no override is given.
- R5: Access kinds 3 (general data), 4 (base-register addressed), 5 (string source) and 7 (other data) use the data segment when no override is given.
- R6: Access kind 6 (string destination) always uses the extra segment, whatever the override inputs are.
- R7: When `ovr_en` is 1 and the access kind is neither 0 nor 6, the segment named by `ovr_sel` is used.
- R8: A write through `seg_wr_en`/`seg_wr_sel`/`seg_wr_data` changes the address only after the next rising clock edge. Before that edge the old value is used.
- R9: After reset all four segment registers are zero, so `phys_addr` equals `offset` for every access kind.
- R10: Bits 3:0 of `phys_addr` always equal bits 3:0 of `offset`, because every segment starts on a 16-byte boundary.
- R11: Segment register select codes are 0 extra, 1 code, 2 stack and 3 data. These codes apply to both `seg_wr_sel` and `ovr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Load the segment register named by seg_wr_sel |
| seg_wr_sel | input | 2 | Segment register to load (R11 codes) |
| seg_wr_data | input | 16 | Value to load |
| acc_kind | input | 3 | Access kind code (R3 to R6) |
| offset | input | 16 | Offset within the segment |
| ovr_en | input | 1 | Use ovr_sel instead of the default segment |
| ovr_sel | input | 2 | Override segment (R11 codes) |
| phys_addr | output | 20 | Physical address |

## Verification
The physical address is combinational from the access kind, the offset and the override. It is therefore due in the same cycle the inputs change. The bench drives inputs on the falling edge and samples a couple of nanoseconds later, well before the next rising edge. A segment write is due one rising edge after it is presented. The bench checks the old value before that edge and the new value in the half-cycle after it. This confirms that the write does not appear early and is not delayed by a cycle.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seg_wr_en,
  input  logic [1:0]             seg_wr_sel,
  input  logic [SEG_W-1:0]       seg_wr_data,
  input  logic [2:0]             acc_kind,
  input  logic [OFF_W-1:0]       offset,
  input  logic                   ovr_en,
  input  logic [1:0]             ovr_sel,
  output logic [SEG_W+SHIFT-1:0] phys_addr
);
  localparam int ADDR_W = SEG_W + SHIFT;

  localparam logic [1:0] SEL_EXTRA = 2'd0;
  localparam logic [1:0] SEL_CODE  = 2'd1;
  localparam logic [1:0] SEL_STACK = 2'd2;
  localparam logic [1:0] SEL_DATA  = 2'd3;

  localparam logic [2:0] K_FETCH  = 3'd0;
  localparam logic [2:0] K_PUSHPOP = 3'd1;
  localparam logic [2:0] K_BPREL  = 3'd2;
  localparam logic [2:0] K_STRDST = 3'd6;

  logic [SEG_W-1:0] seg_q [4];
  logic [1:0]       dflt_sel;
  logic             fixed_kind;
  logic [1:0]       use_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) seg_q[i] <= '0;
    end else if (seg_wr_en) begin
      seg_q[seg_wr_sel] <= seg_wr_data;
    end
  end

  always_comb begin
    case (acc_kind)
      K_FETCH:           dflt_sel = SEL_CODE;
      K_PUSHPOP, K_BPREL: dflt_sel = SEL_STACK;
      K_STRDST:          dflt_sel = SEL_EXTRA;
      default:           dflt_sel = SEL_DATA;
    endcase
  end

  assign fixed_kind = (acc_kind == K_FETCH) || (acc_kind == K_STRDST);
  assign use_sel    = (ovr_en && !fixed_kind) ? ovr_sel : dflt_sel;
  assign phys_addr  = {seg_q[use_sel], {SHIFT{1'b0}}} + ADDR_W'(offset);
endmodule

module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   seg_wr_en,
  input logic [1:0]             seg_wr_sel,
  input logic [SEG_W-1:0]       seg_wr_data,
  input logic [2:0]             acc_kind,
  input logic [OFF_W-1:0]       offset,
  input logic                   ovr_en,
  input logic [1:0]             ovr_sel,
  input logic [SEG_W+SHIFT-1:0] phys_addr
);
  localparam int ADDR_W = SEG_W + SHIFT;

  logic [SEG_W-1:0]  shadow [4];
  logic [ADDR_W-1:0] exp_at [4];
  logic              no_ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) shadow[i] <= '0;
    end else if (seg_wr_en) begin
      shadow[seg_wr_sel] <= seg_wr_data;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_exp
    assign exp_at[g] = {shadow[g], {SHIFT{1'b0}}} + ADDR_W'(offset);
  end

  assign no_ovr = !ovr_en;

  a_r3_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 3'd0 |-> phys_addr == exp_at[1]);

  a_r6_dest_extra: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 3'd6 |-> phys_addr == exp_at[0]);

  a_r4_stack_default: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovr && (acc_kind == 3'd1 || acc_kind == 3'd2)) |-> phys_addr == exp_at[2]);

  a_r5_data_default: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovr && (acc_kind == 3'd3 || acc_kind == 3'd4 || acc_kind == 3'd5 || acc_kind == 3'd7))
      |-> phys_addr == exp_at[3]);

  a_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && acc_kind != 3'd0 && acc_kind != 3'd6) |-> phys_addr == exp_at[ovr_sel]);

  a_r10_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[SHIFT-1:0] == offset[SHIFT-1:0]);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
  .seg_wr_data(seg_wr_data), .acc_kind(acc_kind), .offset(offset),
  .ovr_en(ovr_en), .ovr_sel(ovr_sel), .phys_addr(phys_addr)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic [2:0]  acc_kind = '0;
  logic [15:0] offset = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [19:0] phys_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
    .seg_wr_data(seg_wr_data), .acc_kind(acc_kind), .offset(offset),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .phys_addr(phys_addr)
  );

  // {req[3:0], kind[2:0], ovr_en, ovr_sel[1:0], offset[15:0], expected[19:0]}
  // segments: extra 1234h, code 2050h, stack ABCDh, data FFFFh
  localparam int NV = 14;
  localparam logic [45:0] VEC [NV] = '{
    {4'd1,  3'd0, 1'b0, 2'd0, 16'h0004, 20'h20504}, // R1 fetch
    {4'd3,  3'd0, 1'b1, 2'd3, 16'h0004, 20'h20504}, // R3 override ignored
    {4'd4,  3'd1, 1'b0, 2'd0, 16'h0010, 20'hABCE0}, // R4 push/pop
    {4'd4,  3'd2, 1'b0, 2'd0, 16'hFFFF, 20'hBBCCF}, // R4 bp relative
    {4'd2,  3'd3, 1'b0, 2'd0, 16'h0010, 20'h00000}, // R2 wrap to zero
    {4'd2,  3'd4, 1'b0, 2'd0, 16'hFFFF, 20'h0FFEF}, // R2 wrap, bx data
    {4'd5,  3'd5, 1'b0, 2'd0, 16'h0001, 20'hFFFF1}, // R5 string source
    {4'd6,  3'd6, 1'b0, 2'd0, 16'h0020, 20'h12360}, // R6 string dest
    {4'd6,  3'd6, 1'b1, 2'd1, 16'h0020, 20'h12360}, // R6 override ignored
    {4'd7,  3'd3, 1'b1, 2'd0, 16'h0005, 20'h12345}, // R7 data -> extra
    {4'd7,  3'd1, 1'b1, 2'd1, 16'h0000, 20'h20500}, // R7 stack -> code
    {4'd7,  3'd2, 1'b1, 2'd3, 16'h0003, 20'hFFFF3}, // R7 bp -> data
    {4'd11, 3'd4, 1'b1, 2'd2, 16'h1000, 20'hACCD0}, // R11 bx -> stack code 2
    {4'd5,  3'd7, 1'b0, 2'd0, 16'h0000, 20'hFFFF0}  // R5 other kind
  };

  task automatic check(input int req, input logic [19:0] exp);
    n_run++;
    if (phys_addr !== exp) begin
      n_fail++;
      $display("FAIL R%0d: phys_addr=%05h expected=%05h", req, phys_addr, exp);
    end
  endtask

  task automatic write_seg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset leaves all segments zero
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      acc_kind = 3'(k); offset = 16'h1234; ovr_en = 1'b0;
      #2 check(9, 20'h01234);
    end

    // R8: write visible only after the next rising edge
    @(negedge clk);
    acc_kind = 3'd0; offset = 16'h0004;
    seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h2050;
    #2 check(8, 20'h00004);
    @(posedge clk);
    #2 check(8, 20'h20504);
    @(negedge clk);
    seg_wr_en = 1'b0;

    write_seg(2'd0, 16'h1234);
    write_seg(2'd2, 16'hABCD);
    write_seg(2'd3, 16'hFFFF);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      acc_kind = VEC[v][41:39];
      ovr_en   = VEC[v][38];
      ovr_sel  = VEC[v][37:36];
      offset   = VEC[v][35:20];
      #2 check(int'(VEC[v][45:42]), VEC[v][19:0]);
    end

    // R10: low nibble follows offset for every override target
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      acc_kind = 3'd3; ovr_en = 1'b1; ovr_sel = 2'(s); offset = 16'h0F0B;
      #2 n_run++;
      if (phys_addr[3:0] !== 4'hB) begin
        n_fail++;
        $display("FAIL R10: low nibble=%0h expected=b", phys_addr[3:0]);
      end
    end

    // R3: a code segment rewrite moves fetch addresses
    write_seg(2'd1, 16'hF000);
    @(negedge clk);
    acc_kind = 3'd0; ovr_en = 1'b1; ovr_sel = 2'd2; offset = 16'h0FFF;
    #2 check(3, 20'hF0FFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule